// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block holds the small control registers of a workstation I/O companion device behind a simple synchronous register bus. Each register has its own select line. The byte-wide registers are configuration, diagnostic, modem control, a miscellaneous-function register (aux1) and a power-down control register (aux2). There is also a 16-bit diagnostic LED register, a 32-bit system-control register and a one-byte CPU-idle port. A write is performed in the cycle that carries the write strobe. Read data appears on `rdata` one cycle after the read strobe.

Several registers have side effects. A write to aux1 can fire a floppy terminal-count pulse. Aux2 holds a power-fail flag that is set from an input pin, gated by an enable bit in the configuration register, and cleared by a write. A power-off bit in aux2 requests a shutdown. A system-control write can request a system reset and leaves a reset-status bit behind. A write to the idle port requests a CPU halt. A block reset clears only part of the register set.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `irq` is high exactly while the stored power-fail flag (aux2 bit 5) and the power-interrupt enable (configuration bit 3) are both set. It follows every change to either register.
- R2: When `pwr_fail` differs from its value in the previous cycle, aux2 bit 5 is loaded with `pwr_fail` AND configuration bit 3. While `pwr_fail` is steady, the flag is left alone.
- R3: A legal write to aux1 with data bit 1 set gives a one-cycle `tc_pulse` in the following cycle. The stored aux1 value always has bit 1 at zero, and every other written bit is stored.
- R4: A write to aux2 keeps only data bits 0 (power off) and 1 (flag clear) and ORs in the current power-fail flag. If bit 1 is set, every bit except bit 0 is then cleared. The result is stored.
- R5: A legal aux2 write whose stored value has bit 0 set gives a one-cycle `shutdown_req` in the following cycle.
- R6: A word write to system-control offset 0 with data bit 0 set loads the register with 0x02 and gives a one-cycle `reset_req`. System-control writes at other offsets, and writes with bit 0 clear, change nothing. Reads at other offsets return zero.
- R7: Reset clears configuration, aux1, aux2 and modem control, and holds all request outputs low. Diagnostic, LED and system-control contents survive a reset.
- R8: Size codes are 0 for a byte, 1 for a half-word and 2 for a word. The byte registers and the idle port need code 0, the LED register code 1 and system control code 2. A write with any other code is ignored, and a read with any other code returns zero.
- R9: Configuration, diagnostic, modem control and LED are plain storage that read back what was written, zero-extended to 32 bits.
- R10: A legal write to the idle port gives a one-cycle `halt_req` in the following cycle. Reads of the idle port return zero.
- R11: `rdata` carries the selected value in the cycle after a read strobe and is zero after any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_cfg | input | 1 | Select configuration register |
| sel_diag | input | 1 | Select diagnostic register |
| sel_modem | input | 1 | Select modem control register |
| sel_aux1 | input | 1 | Select aux1 register |
| sel_aux2 | input | 1 | Select aux2 register |
| sel_led | input | 1 | Select LED register |
| sel_sys | input | 1 | Select system-control register |
| sel_idle | input | 1 | Select CPU-idle port |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| acc_size | input | 2 | Access size code |
| acc_off | input | OFF_W | Byte offset inside the selected window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after `rd` |
| pwr_fail | input | 1 | Power-fail indication |
| irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Floppy terminal-count pulse |
| shutdown_req | output | 1 | Shutdown request pulse |
| reset_req | output | 1 | System reset request pulse |
| halt_req | output | 1 | CPU halt request pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 16-bit LED register and a 2-bit offset. With these values the word-wide system-control offsets, zero-extension of the narrow registers into the full read bus, and every illegal size code can all be exercised. The scenarios cover the power-fail flag being set, masked by the enable bit, cleared by write and cleared by a falling input. They also check that diagnostic, LED and system-control contents survive a second reset.

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs #(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_cfg,
  input  logic              sel_diag,
  input  logic              sel_modem,
  input  logic              sel_aux1,
  input  logic              sel_aux2,
  input  logic              sel_led,
  input  logic              sel_sys,
  input  logic              sel_idle,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        acc_size,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_fail,
  output logic              irq,
  output logic              tc_pulse,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              halt_req
);
  localparam int RW = 8;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam int B_PIE = 3;
  localparam int B_PF  = 5;
  localparam int B_TC  = 1;
  localparam int B_OFF = 0;
  localparam int B_CLR = 1;
  localparam int B_RST = 0;
  localparam logic [RW-1:0] SYS_RSTAT = 8'h02;

  logic [RW-1:0]    cfg_q, diag_q, modem_q, aux1_q, aux2_q, sys_q;
  logic [LED_W-1:0] led_q;
  logic             pf_q;
  logic             pf_flag_n;
  logic [RW-1:0]    aux2_wv, aux1_wv;
  logic [DATA_W-1:0] rd_val;

  wire byte_ok = acc_size == SZ_BYTE;
  wire half_ok = acc_size == SZ_HALF;
  wire word_ok = acc_size == SZ_WORD;
  wire off0    = acc_off == '0;

  wire w_cfg   = wr & sel_cfg   & byte_ok;
  wire w_diag  = wr & sel_diag  & byte_ok;
  wire w_modem = wr & sel_modem & byte_ok;
  wire w_aux1  = wr & sel_aux1  & byte_ok;
  wire w_aux2  = wr & sel_aux2  & byte_ok;
  wire w_led   = wr & sel_led   & half_ok;
  wire w_sys   = wr & sel_sys   & word_ok & off0 & wdata[B_RST];
  wire w_idle  = wr & sel_idle  & byte_ok;

  wire [RW-1:0] wbyte = wdata[RW-1:0];

  assign irq = aux2_q[B_PF] & cfg_q[B_PIE];

  always_comb begin
    pf_flag_n = aux2_q[B_PF];
    if (pwr_fail != pf_q) pf_flag_n = pwr_fail & cfg_q[B_PIE];
    aux2_wv = '0;
    aux2_wv[B_OFF] = wbyte[B_OFF];
    aux2_wv[B_CLR] = wbyte[B_CLR];
    aux2_wv[B_PF]  = pf_flag_n;
    if (wbyte[B_CLR]) aux2_wv = aux2_wv & (RW'(1) << B_OFF);
    aux1_wv = wbyte;
    aux1_wv[B_TC] = 1'b0;
  end

  always_comb begin
    rd_val = '0;
    if (sel_cfg & byte_ok)            rd_val = DATA_W'(cfg_q);
    else if (sel_diag & byte_ok)      rd_val = DATA_W'(diag_q);
    else if (sel_modem & byte_ok)     rd_val = DATA_W'(modem_q);
    else if (sel_aux1 & byte_ok)      rd_val = DATA_W'(aux1_q);
    else if (sel_aux2 & byte_ok)      rd_val = DATA_W'(aux2_q);
    else if (sel_led & half_ok)       rd_val = DATA_W'(led_q);
    else if (sel_sys & word_ok & off0) rd_val = DATA_W'(sys_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      modem_q      <= '0;
      aux1_q       <= '0;
      aux2_q       <= '0;
      pf_q         <= 1'b0;
      rdata        <= '0;
      tc_pulse     <= 1'b0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      halt_req     <= 1'b0;
    end else begin
      pf_q <= pwr_fail;
      if (w_cfg)   cfg_q   <= wbyte;
      if (w_modem) modem_q <= wbyte;
      if (w_aux1)  aux1_q  <= aux1_wv;
      if (w_aux2)  aux2_q  <= aux2_wv;
      else         aux2_q[B_PF] <= pf_flag_n;
      rdata        <= rd ? rd_val : '0;
      tc_pulse     <= w_aux1 & wbyte[B_TC];
      shutdown_req <= w_aux2 & aux2_wv[B_OFF];
      reset_req    <= w_sys;
      halt_req     <= w_idle;
    end
  end

  always_ff @(posedge clk) begin
    if (w_diag) diag_q <= wbyte;
    if (w_led)  led_q  <= wdata[LED_W-1:0];
    if (w_sys)  sys_q  <= SYS_RSTAT;
  end
endmodule

module aux_sysctl_regs_chk #(
  parameter int OFF_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_cfg,
  input logic             sel_diag,
  input logic             sel_modem,
  input logic             sel_aux1,
  input logic             sel_aux2,
  input logic             sel_led,
  input logic             sel_sys,
  input logic             sel_idle,
  input logic             wr,
  input logic [1:0]       acc_size,
  input logic [OFF_W-1:0] acc_off,
  input logic [1:0]       wd,
  input logic             pwr_fail,
  input logic             pf_q,
  input logic [7:0]       cfg_q,
  input logic [7:0]       aux1_q,
  input logic [7:0]       aux2_q,
  input logic [7:0]       sys_q,
  input logic             irq,
  input logic             tc_pulse,
  input logic             shutdown_req,
  input logic             reset_req,
  input logic             halt_req
);
  wire bw = wr & (acc_size == 2'd0);

  p_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_cfg, sel_diag, sel_modem, sel_aux1, sel_aux2, sel_led, sel_sys, sel_idle}));

  p_pf_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail != pf_q && !(wr && (sel_aux2 || sel_cfg)))
    |=> (aux2_q[5] == ($past(pwr_fail) && $past(cfg_q[3]))));

  p_pf_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail && !pf_q && cfg_q[3] && !(wr && (sel_aux2 || sel_cfg))) |=> irq);

  p_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bw && sel_aux1 && wd[1]) |=> (tc_pulse && !aux1_q[1]));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bw && sel_aux2 && wd[1]) |=> (!aux2_q[5] && !irq));

  p_shutdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bw && sel_aux2 && wd[0]) |=> shutdown_req);

  p_sysreset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_sys && acc_size == 2'd2 && acc_off == '0 && wd[0])
    |=> (reset_req && sys_q == 8'h02));

  p_badsize_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_cfg && acc_size != 2'd0) |=> $stable(cfg_q));

  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bw && sel_idle) |=> halt_req);

  p_reset_quiet_r7: assert property (@(posedge clk)
    $past(!rst_n) |-> (!tc_pulse && !shutdown_req && !reset_req && !halt_req && cfg_q == 8'h00));
endmodule

bind aux_sysctl_regs aux_sysctl_regs_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sel_cfg(sel_cfg), .sel_diag(sel_diag), .sel_modem(sel_modem),
  .sel_aux1(sel_aux1), .sel_aux2(sel_aux2), .sel_led(sel_led),
  .sel_sys(sel_sys), .sel_idle(sel_idle),
  .wr(wr), .acc_size(acc_size), .acc_off(acc_off), .wd(wdata[1:0]),
  .pwr_fail(pwr_fail), .pf_q(pf_q), .cfg_q(cfg_q), .aux1_q(aux1_q),
  .aux2_q(aux2_q), .sys_q(sys_q), .irq(irq), .tc_pulse(tc_pulse),
  .shutdown_req(shutdown_req), .reset_req(reset_req), .halt_req(halt_req)
);

// File: tb/tb_aux_sysctl_regs.sv
module tb_aux_sysctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int S_CFG = 0, S_DIAG = 1, S_MDM = 2, S_AUX1 = 3;
  localparam int S_AUX2 = 4, S_LED = 5, S_SYS = 6, S_IDLE = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sels = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  acc_size = '0;
  logic [1:0]  acc_off = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwr_fail = 1'b0;
  logic        irq, tc_pulse, shutdown_req, reset_req, halt_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_sysctl_regs dut (
    .clk(clk), .rst_n(rst_n),
    .sel_cfg(sels[S_CFG]), .sel_diag(sels[S_DIAG]), .sel_modem(sels[S_MDM]),
    .sel_aux1(sels[S_AUX1]), .sel_aux2(sels[S_AUX2]), .sel_led(sels[S_LED]),
    .sel_sys(sels[S_SYS]), .sel_idle(sels[S_IDLE]),
    .wr(wr), .rd(rd), .acc_size(acc_size), .acc_off(acc_off),
    .wdata(wdata), .rdata(rdata), .pwr_fail(pwr_fail), .irq(irq),
    .tc_pulse(tc_pulse), .shutdown_req(shutdown_req),
    .reset_req(reset_req), .halt_req(halt_req)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit was_rd;
    was_rd = rd;
    #3;
    if (was_rd) begin
      if (sb.size() == 0) check(0, "R11 unexpected read", rdata, '0);
      else begin
        rd_item_t it;
        it = sb.pop_front();
        check(rdata === it.exp, it.tag, rdata, it.exp);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_acc(input int s, input logic [1:0] sz, input logic [1:0] off, input logic [31:0] d);
    sels = 8'(1 << s); wr = 1'b1; acc_size = sz; acc_off = off; wdata = d;
    tick();
    sels = '0; wr = 1'b0; wdata = '0; acc_off = '0; acc_size = '0;
  endtask

  task automatic rd_acc(input int s, input logic [1:0] sz, input logic [1:0] off, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    sels = 8'(1 << s); rd = 1'b1; acc_size = sz; acc_off = off;
    tick();
    sels = '0; rd = 1'b0; acc_off = '0; acc_size = '0;
  endtask

  task automatic pulses(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {tc_pulse, shutdown_req, reset_req, halt_req};
    check(act === exp, tag, 32'(act), 32'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    tick();
    do_reset();
    pulses(4'b0000, "R7 request outputs low after reset");
    check(irq === 1'b0, "R7 irq low after reset", 32'(irq), 0);
    rd_acc(S_CFG, 0, 0, 32'h0, "R7 cfg cleared");
    rd_acc(S_AUX1, 0, 0, 32'h0, "R7 aux1 cleared");
    rd_acc(S_AUX2, 0, 0, 32'h0, "R7 aux2 cleared");
    rd_acc(S_MDM, 0, 0, 32'h0, "R7 modem cleared");
    tick();
    check(rdata === 32'h0, "R11 rdata zero without read", rdata, 0);

    wr_acc(S_CFG, 0, 0, 32'hFFFF_FF52);
    wr_acc(S_DIAG, 0, 0, 32'h0000_00C3);
    wr_acc(S_MDM, 0, 0, 32'h0000_003C);
    wr_acc(S_LED, 1, 0, 32'h1234_BEEF);
    rd_acc(S_CFG, 0, 0, 32'h52, "R9 cfg readback");
    rd_acc(S_DIAG, 0, 0, 32'hC3, "R9 diag readback");
    rd_acc(S_MDM, 0, 0, 32'h3C, "R9 modem readback");
    rd_acc(S_LED, 1, 0, 32'hBEEF, "R9 led readback");

    wr_acc(S_CFG, 2, 0, 32'hFF);
    wr_acc(S_CFG, 3, 0, 32'hFF);
    rd_acc(S_CFG, 0, 0, 32'h52, "R8 cfg bad-size writes ignored");
    rd_acc(S_CFG, 1, 0, 32'h0, "R8 cfg half read zero");
    wr_acc(S_LED, 0, 0, 32'h11);
    rd_acc(S_LED, 1, 0, 32'hBEEF, "R8 led byte write ignored");
    rd_acc(S_LED, 2, 0, 32'h0, "R8 led word read zero");
    wr_acc(S_AUX1, 2, 0, 32'h02);
    pulses(4'b0000, "R8 aux1 word write no pulse");

    wr_acc(S_AUX1, 0, 0, 32'hFF);
    pulses(4'b1000, "R3 tc pulse");
    tick();
    pulses(4'b0000, "R3 tc one cycle");
    rd_acc(S_AUX1, 0, 0, 32'hFD, "R3 aux1 bit1 not stored");
    wr_acc(S_AUX1, 0, 0, 32'h01);
    pulses(4'b0000, "R3 no tc without bit1");
    rd_acc(S_AUX1, 0, 0, 32'h01, "R3 aux1 stored");

    wr_acc(S_CFG, 0, 0, 32'h08);
    pwr_fail = 1'b1; tick();
    check(irq === 1'b1, "R2 pf sets flag irq", 32'(irq), 1);
    rd_acc(S_AUX2, 0, 0, 32'h20, "R2 aux2 flag set");
    wr_acc(S_CFG, 0, 0, 32'h00);
    check(irq === 1'b0, "R1 irq masked by enable", 32'(irq), 0);
    rd_acc(S_AUX2, 0, 0, 32'h20, "R1 flag kept while masked");
    wr_acc(S_CFG, 0, 0, 32'h08);
    check(irq === 1'b1, "R1 irq back on enable", 32'(irq), 1);

    wr_acc(S_AUX2, 0, 0, 32'hFC);
    rd_acc(S_AUX2, 0, 0, 32'h20, "R4 upper bits dropped flag kept");
    check(irq === 1'b1, "R4 irq kept", 32'(irq), 1);
    wr_acc(S_AUX2, 0, 0, 32'h02);
    check(irq === 1'b0, "R4 clear drops irq", 32'(irq), 0);
    rd_acc(S_AUX2, 0, 0, 32'h00, "R4 clear stored");
    tick();
    check(irq === 1'b0, "R2 steady input leaves flag", 32'(irq), 0);

    pwr_fail = 1'b0; tick();
    wr_acc(S_CFG, 0, 0, 32'h00);
    pwr_fail = 1'b1; tick();
    rd_acc(S_AUX2, 0, 0, 32'h00, "R2 flag gated by enable");
    pwr_fail = 1'b0; tick();
    wr_acc(S_CFG, 0, 0, 32'h08);
    pwr_fail = 1'b1; tick();
    check(irq === 1'b1, "R2 rise with enable", 32'(irq), 1);
    pwr_fail = 1'b0; tick();
    check(irq === 1'b0, "R2 fall clears flag", 32'(irq), 0);
    rd_acc(S_AUX2, 0, 0, 32'h00, "R2 flag cleared on fall");

    wr_acc(S_AUX2, 0, 0, 32'h01);
    pulses(4'b0100, "R5 shutdown pulse");
    tick();
    pulses(4'b0000, "R5 shutdown one cycle");
    rd_acc(S_AUX2, 0, 0, 32'h01, "R5 power-off stored");
    wr_acc(S_AUX2, 0, 0, 32'h03);
    pulses(4'b0100, "R5 shutdown with clear");
    rd_acc(S_AUX2, 0, 0, 32'h01, "R4 clear keeps bit0");
    wr_acc(S_AUX2, 0, 0, 32'h02);
    pulses(4'b0000, "R5 no shutdown");

    wr_acc(S_SYS, 2, 1, 32'h01);
    pulses(4'b0000, "R6 other offset ignored");
    wr_acc(S_SYS, 1, 0, 32'h01);
    pulses(4'b0000, "R8 sys half write ignored");
    wr_acc(S_SYS, 2, 0, 32'h01);
    pulses(4'b0010, "R6 reset request");
    tick();
    pulses(4'b0000, "R6 reset request one cycle");
    rd_acc(S_SYS, 2, 0, 32'h02, "R6 status latched");
    rd_acc(S_SYS, 2, 2, 32'h00, "R6 other offset reads zero");
    wr_acc(S_SYS, 2, 0, 32'h00);
    pulses(4'b0000, "R6 bit0 clear no request");
    rd_acc(S_SYS, 2, 0, 32'h02, "R6 bit0 clear keeps status");

    wr_acc(S_IDLE, 0, 0, 32'hA5);
    pulses(4'b0001, "R10 halt pulse");
    tick();
    pulses(4'b0000, "R10 halt one cycle");
    rd_acc(S_IDLE, 0, 0, 32'h0, "R10 idle reads zero");

    wr_acc(S_MDM, 0, 0, 32'h77);
    wr_acc(S_CFG, 0, 0, 32'h08);
    do_reset();
    rd_acc(S_DIAG, 0, 0, 32'hC3, "R7 diag survives reset");
    rd_acc(S_SYS, 2, 0, 32'h02, "R7 sys survives reset");
    rd_acc(S_LED, 1, 0, 32'hBEEF, "R7 led survives reset");
    rd_acc(S_MDM, 0, 0, 32'h00, "R7 modem cleared again");
    rd_acc(S_CFG, 0, 0, 32'h00, "R7 cfg cleared again");
    tick();
    check(sb.size() == 0, "R11 all reads returned", 32'(sb.size()), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule